// File: doc/BRIEF.md
# Buffered SPI Master with Completion Interrupt

This block is a memory-mapped SPI master that moves data through one shared byte buffer. Software writes the outgoing bytes into the buffer. It then writes a single 16-bit control word that carries a byte count, a go bit, an interrupt-enable bit and a bit that closes the message. The engine shifts the bytes out in SPI mode 0, most significant bit first. Each byte clocked in from the slave replaces the outgoing byte in the same buffer slot, so the reply is read from where the request was written.

A long message is sent as several fragments. Chip select stays low between fragments until a fragment marked as the closing one completes. At the end of every fragment a pending flag is set. Software clears it by writing a one to it, and the interrupt line is high while both the flag and the enable bit are set. A separate register sets the serial clock rate as a divided system clock.

Top module: `spim_buffered`

## Requirements
- R1: After reset spi_cs_n is 1, spi_sclk and spi_mosi are 0, irq is 0, and the control and divider registers read 0.
- R2: Byte address a < BUF_BYTES reaches buffer byte a through bus_wdata[7:0] and bus_rdata[7:0]. The control register sits at address BUF_BYTES and the divider register at BUF_BYTES+2. Read data is valid in the cycle after bus_rd.
- R3: A control write with bit 15 set while idle starts a fragment of bits 9:0 bytes, taken from buffer offsets 0 upward. A count of 0 means BUF_BYTES (1024) bytes.
- R4: spi_sclk idles low. Each byte goes out MSB first on spi_mosi, which changes only while spi_sclk is low. spi_miso is sampled on the rising edge.
- R5: Each spi_sclk high phase and low phase inside a byte lasts divider+1 system clock cycles.
- R6: Every byte received during a fragment overwrites the transmitted byte at the same buffer offset.
- R7: Control bit 15 reads 1 while a fragment runs and 0 once it ends. While it runs, writes to the go bit, the count, bit 14 and the divider register are ignored.
- R8: spi_cs_n goes low when a fragment starts and stays low throughout it. It returns high at the end only if bit 14 was set in the starting write, and otherwise stays low for the next fragment.
- R9: A control write with bit 14 set and bit 15 clear, made while idle, drives spi_cs_n high.
- R10: Control bit 12 (pending) is set once at the end of each fragment. Writing 1 to bit 12 clears it.
- R11: irq is 1 exactly when pending (bit 12) and enable (bit 13) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address into the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_wdata | input | 16 | Write data (buffer uses bits 7:0) |
| bus_rdata | output | 16 | Read data |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |
| irq | output | 1 | Completion interrupt, level |

## Verification
The assertions take for granted that reset is held for at least one clock. They also assume that software leaves the buffer alone while the go bit reads 1, because during a fragment the engine owns the single buffer port. The stimulus respects this by polling the go bit before any buffer access. The bench's slave model changes spi_miso only after a falling spi_sclk, so the value is settled well before the rising edge that samples it, at every divider value in the sweep.

// File: rtl/spim_pkg.sv
// Package: shared control-word bit positions and engine state type.
// Assumes a 16-bit control register; bit positions are fixed by software.
package spim_pkg;
    localparam int CTL_GO   = 15;
    localparam int CTL_LAST = 14;
    localparam int CTL_IE   = 13;
    localparam int CTL_PEND = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE
    } spim_state_t;
endpackage

// File: rtl/spim_bufram.sv
// Module: single-port byte buffer with registered read.
// Assumes one access per cycle; q always shows the byte addressed in the
// previous cycle (read-before-write on a same-address write).
module spim_bufram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wd,
    output logic [7:0]    q
);
    logic [7:0] mem [DEPTH];

    // write port and registered read
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
        q <= mem[addr];
    end
endmodule

// File: rtl/spim_clkgen.sv
// Module: half-period tick generator for the serial clock.
// Assumes div is stable while run is high; tick fires every div+1 cycles.
module spim_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == div);

    // count cycles of one half period, restart when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spim_shift.sv
// Module: mode-0 byte shifter, MSB first.
// Assumes load only while inactive; sclk rises on odd ticks (sample),
// falls on even ticks (advance); done pulses after the last falling edge.
module spim_shift #(
    parameter int BITS = 8,
    localparam int CW = $clog2(BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] din,
    input  logic            tick,
    input  logic            miso,
    output logic            active,
    output logic            sclk,
    output logic            mosi,
    output logic            done,
    output logic [BITS-1:0] dout
);
    logic [BITS-1:0] tx;
    logic [CW-1:0]   bitc;

    assign mosi = active ? tx[BITS-1] : 1'b0;

    // shift state: load, sample on rise, advance on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx <= '0; dout <= '0; bitc <= '0;
            active <= 1'b0; sclk <= 1'b0; done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                tx <= din; bitc <= '0; active <= 1'b1; sclk <= 1'b0;
            end else if (active && tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    dout <= {dout[BITS-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    tx   <= {tx[BITS-2:0], 1'b0};
                    bitc <= bitc + 1'b1;
                    if (bitc == CW'(BITS-1)) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spim_buffered.sv
// Module: top of the buffered SPI master.
// Assumes BUF_BYTES is a power of two up to 2048 and that the buffer is
// not accessed by software while a fragment runs (engine owns the port).
module spim_buffered
    import spim_pkg::*;
#(
    parameter int BUF_BYTES = 1024,
    parameter int DIV_W = 8,
    localparam int LEN_W = $clog2(BUF_BYTES),
    localparam int ADDR_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n,
    output logic              irq
);
    spim_state_t      state;
    logic [LEN_W-1:0] idx, len_q;
    logic [DIV_W-1:0] div_q;
    logic             last_q, ie_q, pend_q, busy, rd_buf;
    logic [15:0]      reg_q, ctl_view;
    logic             sel_buf, sel_ctl, sel_div, wr_ctl, go, frag_end;
    logic             tick, sh_active, sh_done;
    logic [7:0]       ram_q, rx_byte;
    logic [LEN_W-1:0] ram_addr;
    logic             ram_we;
    logic [7:0]       ram_wd;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign sel_buf  = !bus_addr[ADDR_W-1];
    assign sel_ctl  = bus_addr == ADDR_W'(BUF_BYTES);
    assign sel_div  = bus_addr == ADDR_W'(BUF_BYTES + 2);
    assign busy     = state != ST_IDLE;
    assign wr_ctl   = bus_wr && sel_ctl;
    assign go       = wr_ctl && !busy && bus_wdata[CTL_GO];
    assign frag_end = (state == ST_STORE) && (idx == LEN_W'(len_q - 1'b1));
    assign irq      = pend_q && ie_q;

    // buffer port: engine while busy, software otherwise
    assign ram_addr = busy ? idx : bus_addr[LEN_W-1:0];
    assign ram_we   = busy ? (state == ST_STORE) : (bus_wr && sel_buf);
    assign ram_wd   = busy ? rx_byte : bus_wdata[7:0];

    spim_bufram #(.DEPTH(BUF_BYTES)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wd(ram_wd), .q(ram_q)
    );

    spim_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(sh_active), .div(div_q), .tick(tick)
    );

    spim_shift #(.BITS(8)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(state == ST_LOAD), .din(ram_q),
        .tick(tick), .miso(spi_miso), .active(sh_active), .sclk(spi_sclk),
        .mosi(spi_mosi), .done(sh_done), .dout(rx_byte)
    );

    // assemble the control word as software sees it
    always_comb begin
        ctl_view = '0;
        ctl_view[LEN_W-1:0] = len_q;
        ctl_view[CTL_PEND]  = pend_q;
        ctl_view[CTL_IE]    = ie_q;
        ctl_view[CTL_LAST]  = last_q;
        ctl_view[CTL_GO]    = busy;
    end

    // control, divider, chip-select and pending-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0; div_q <= '0;
            last_q <= 1'b0; ie_q <= 1'b0; pend_q <= 1'b0; spi_cs_n <= 1'b1;
        end else begin
            if (wr_ctl) ie_q <= bus_wdata[CTL_IE];
            if (wr_ctl && !busy) begin
                last_q <= bus_wdata[CTL_LAST];
                len_q  <= bus_wdata[LEN_W-1:0];
            end
            if (bus_wr && sel_div && !busy) div_q <= bus_wdata[DIV_W-1:0];
            if (frag_end) pend_q <= 1'b1;
            else if (wr_ctl && bus_wdata[CTL_PEND]) pend_q <= 1'b0;
            if (go) spi_cs_n <= 1'b0;
            else if (frag_end && last_q) spi_cs_n <= 1'b1;
            else if (wr_ctl && !busy && bus_wdata[CTL_LAST]) spi_cs_n <= 1'b1;
        end
    end

    // fragment sequencer: fetch, load, shift, store per byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE; idx <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (go) begin state <= ST_FETCH; idx <= '0; end
                ST_FETCH: state <= ST_LOAD;
                ST_LOAD:  state <= ST_SHIFT;
                ST_SHIFT: if (sh_done) state <= ST_STORE;
                ST_STORE: begin
                    if (frag_end) state <= ST_IDLE;
                    else begin state <= ST_FETCH; idx <= idx + 1'b1; end
                end
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // read data register, valid the cycle after bus_rd
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_buf <= 1'b0; reg_q <= '0;
        end else if (bus_rd) begin
            rd_buf <= sel_buf;
            reg_q  <= sel_ctl ? ctl_view : (sel_div ? 16'(div_q) : 16'h0);
        end
    end

    assign bus_rdata = rd_buf ? {8'h00, ram_q} : reg_q;
endmodule

// File: rtl/spim_buffered_chk.sv
// Module: protocol checker bound into spim_buffered.
// Assumes reset is held at least one cycle before checks apply.
module spim_buffered_chk #(
    parameter int LEN_W = 10,
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             cs_n,
    input logic             sclk,
    input logic             mosi,
    input logic             pend,
    input logic [LEN_W-1:0] len_q,
    input logic [DIV_W-1:0] div_q
);
    // R8
    busy_holds_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cs_n);
    // R4
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    // R4
    mosi_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R10
    pend_rise_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $fell(busy));
    // R10
    end_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> pend);
    // R7
    len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(len_q));
    // R7
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div_q));
endmodule

bind spim_buffered spim_buffered_chk #(.LEN_W(LEN_W), .DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(spi_cs_n), .sclk(spi_sclk),
    .mosi(spi_mosi), .pend(pend_q), .len_q(len_q), .div_q(div_q)
);

// File: tb/spim_buffered_test.sv
`timescale 1ns/1ps
module spim_buffered_test;
    localparam int NB = 1024;
    localparam int CTL = NB;
    localparam int DIVA = NB + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sclk, spi_mosi, spi_cs_n, irq;
    logic        spi_miso = 1'b0;

    int tests = 0, fails = 0, cycles = 0;
    int cur_div = 0, exp_k = 0;

    // slave model state (written only by the slave process)
    logic [7:0] got [0:4095];
    int s_total = 0, s_idx = 0, s_bit = 0, hi_run = 0, bad_runs = 0;
    logic [7:0] s_tx = '0, s_rx = '0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    spim_buffered uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] fval(int k);
        return 8'(k * 37 + 5) ^ 8'hA5;
    endfunction

    function automatic logic [7:0] gval(int i, int n, int d);
        return 8'(i * 13 + n * 3 + d * 71 + 1);
    endfunction

    // mode-0 slave: sample on rise, present next bit after fall
    always @(negedge clk) begin
        if (prev_cs && !spi_cs_n) begin
            s_idx = 0; s_tx = fval(0); s_bit = 0; spi_miso = s_tx[7];
        end
        if (!prev_sclk && spi_sclk) begin
            s_rx = {s_rx[6:0], spi_mosi};
            s_bit = s_bit + 1;
            if (s_bit == 8) begin got[s_total] = s_rx; s_total = s_total + 1; end
        end
        if (spi_sclk) hi_run = hi_run + 1;
        if (prev_sclk && !spi_sclk) begin
            if (hi_run != cur_div + 1) bad_runs = bad_runs + 1;
            hi_run = 0;
            if (s_bit == 8) begin
                s_idx = s_idx + 1; s_tx = fval(s_idx); s_bit = 0;
            end else s_tx = {s_tx[6:0], 1'b0};
            spi_miso = s_tx[7];
        end
        prev_cs = spi_cs_n;
        prev_sclk = spi_sclk;
    end

    // watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            tests = tests + 1; fails = fails + 1;
            $display("FAIL watchdog: got %0d cycles expected < 190000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bwr(input int a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = 11'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input int a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = 11'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int t = 0; t < 40000; t++) begin
            brd(CTL, v);
            if (!v[15]) break;
        end
    endtask

    // one fragment with full checking
    task automatic run_frag(input int n, input bit last, input bit ie, input int d);
        int nb, base, br0, bad;
        logic [15:0] v;
        nb = (n == 0) ? NB : n;
        bwr(DIVA, 16'(d));
        cur_div = d;
        for (int i = 0; i < nb; i++) bwr(i, {8'h00, gval(i, n, d)});
        base = s_total; br0 = bad_runs;
        bwr(CTL, {1'b1, last, ie, 3'b000, 10'(n)});
        brd(CTL, v);
        chk(v[15] == 1'b1, "R7 busy bit", int'(v[15]), 1);
        wait_idle();
        chk(s_total - base == nb, "R3 byte count", s_total - base, nb);
        bad = 0;
        for (int i = 0; i < nb; i++) if (got[base + i] != gval(i, n, d)) bad++;
        chk(bad == 0, "R4 mosi bytes", bad, 0);
        chk(bad_runs == br0, "R5 sclk half period", bad_runs - br0, 0);
        bad = 0;
        for (int i = 0; i < nb; i++) begin
            brd(i, v);
            if (v[7:0] != fval(exp_k + i)) bad++;
        end
        chk(bad == 0, "R6 in-place reply", bad, 0);
        brd(CTL, v);
        chk(v[12] == 1'b1, "R10 pending set", int'(v[12]), 1);
        chk(irq == ie, "R11 irq level", int'(irq), int'(ie));
        chk(spi_cs_n == last, "R8 cs after fragment", int'(spi_cs_n), int'(last));
        exp_k = last ? 0 : exp_k + nb;
    endtask

    initial begin
        logic [15:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(spi_cs_n == 1'b1 && spi_sclk == 1'b0 && spi_mosi == 1'b0 && irq == 1'b0,
            "R1 pins", {spi_cs_n, spi_sclk, spi_mosi, irq}, 4'b1000);
        brd(CTL, v);  chk(v == 16'h0, "R1 control", v, 0);
        brd(DIVA, v); chk(v == 16'h0, "R1 divider", v, 0);

        // R2 buffer access
        bwr(5, 16'h003C);   brd(5, v);    chk(v == 16'h3C, "R2 buffer 5", v, 16'h3C);
        bwr(1023, 16'h00C3); brd(1023, v); chk(v == 16'hC3, "R2 buffer 1023", v, 16'hC3);
        bwr(DIVA, 16'h0007); brd(DIVA, v); chk(v == 16'h7, "R2 divider", v, 7);

        // sweep divider and length
        for (int d = 0; d < 4; d++) begin
            for (int li = 0; li < 4; li++) begin
                int n;
                n = (li == 0) ? 1 : (li == 1) ? 2 : (li == 2) ? 3 : 7;
                run_frag(n, 1'b1, 1'((d + li) % 2), d);
                bwr(CTL, 16'h1000);
                brd(CTL, v);
                chk(v[12] == 1'b0 && irq == 1'b0, "R10 clear pending",
                    {v[12], irq}, 0);
            end
        end

        // R8 split message: chip select held, slave byte index continues
        run_frag(3, 1'b0, 1'b1, 1);
        bwr(CTL, 16'h1000);
        chk(spi_cs_n == 1'b0, "R8 cs held between fragments", int'(spi_cs_n), 0);
        run_frag(2, 1'b1, 1'b1, 1);
        bwr(CTL, 16'h1000);

        // R9 forced release
        run_frag(2, 1'b0, 1'b0, 0);
        bwr(CTL, 16'h4000);
        chk(spi_cs_n == 1'b1, "R9 forced release", int'(spi_cs_n), 1);
        bwr(CTL, 16'h0000);
        chk(spi_cs_n == 1'b1, "R9 stays released", int'(spi_cs_n), 1);
        exp_k = 0;

        // R7 writes during a fragment are ignored
        bwr(DIVA, 16'd3);
        cur_div = 3;
        for (int i = 0; i < 4; i++) bwr(i, {8'h00, 8'(i + 8'h50)});
        base = s_total;
        bwr(CTL, 16'hC004);
        bwr(CTL, 16'h8009);
        bwr(DIVA, 16'd0);
        wait_idle();
        chk(s_total - base == 4, "R7 restart ignored", s_total - base, 4);
        brd(DIVA, v); chk(v == 16'd3, "R7 divider kept", v, 3);
        brd(CTL, v);  chk(v[9:0] == 10'd4, "R7 length kept", v[9:0], 4);
        bwr(CTL, 16'h1000);

        // R3 zero count means full buffer
        run_frag(0, 1'b1, 1'b1, 0);
        bwr(CTL, 16'h1000);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule